// File: doc/BRIEF.md
# BiSS C Sensor-Side Frame Transmitter

This block is the serializer on the sensor end of a point-to-point BiSS C link. It watches the clock line driven by the controller. On the first rising edge of a request it freezes a snapshot of the position word and the error and warning flags. On the second rising edge it pulls its data line low to acknowledge. The line stays low for a fixed number of further clock edges, which stands for the sensor's conversion time. After that the block shifts out one frame bit on each rising edge.

A frame is a high start bit, the echo of the last control bit received, the position MSB first, the error flag, the warning flag and a 6-bit CRC. The controller ends a frame by letting its clock rest. Once the clock has shown no edge for a set number of system cycles, the block takes the resting clock level as the new control bit and shows it on `cdm_o`. It then releases the data line high and waits for the next request. If the clock rests low, the block only arms again after the clock has returned high. That following rise therefore does not start a frame.

The clock line is asynchronous to the system clock and passes through a synchronizer of `SYNC_STAGES` flops. The data line changes `SYNC_STAGES + 1` system cycles after a clock-line rising edge.

Top module: `biss_slave_tx`

## Requirements
- R1: In idle, a rising edge of `ma_i` captures `pos_i`, `err_i` and `warn_i` and leaves `sl_o` high. Changes on those inputs after that edge do not alter the frame being sent.
- R2: The second rising edge of a frame drives `sl_o` low (acknowledge).
- R3: `sl_o` stays low for `BUSY_CYC` further rising edges. The next rising edge drives the start bit, which is 1.
- R4: After the start bit, each rising edge outputs one bit in this order: echo bit, position bits from MSB to LSB, error flag, warning flag, then the CRC MSB first. `sl_o` changes only on rising edges of `ma_i` or at a timeout.
- R5: The echo bit equals the control bit received at the end of the previous frame. It is 0 for the first frame after reset.
- R6: The CRC uses polynomial x^6+x+1 (0x43) with a zero initial value. It is computed MSB first over the position, the error flag and the warning flag, and is sent inverted.
- R7: A frame ends when `ma_i` shows no edge for `TIMEOUT_CYC` system cycles. The level of `ma_i` at that moment becomes the new control bit, and `cdm_o` shows it.
- R8: At the timeout `sl_o` returns high. If `ma_i` was low at the timeout, the next rise of `ma_i` only re-arms the block and does not start a frame.
- R9: After the last CRC bit, any further rising edges keep `sl_o` low until the timeout.
- R10: After reset `sl_o` is 1 and `cdm_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ma_i | input | 1 | Clock line from the controller, asynchronous |
| pos_i | input | POS_W | Position word to report |
| err_i | input | 1 | Error flag to report |
| warn_i | input | 1 | Warning flag to report |
| sl_o | output | 1 | Data line back to the controller, idle high |
| cdm_o | output | 1 | Last control bit taken from the clock level at timeout |

## Verification
The hardest situation to reach is a frame that ends with the clock resting low. In that case the next clock rise must only re-arm the block and must not count as a request. A frame cut off part-way through its data must also still deliver a valid control bit. The stimulus runs frames back to back with random control bits, random extra trailing edges and occasional early aborts. A wrongly started frame would then show up as a low data line on the next request's first edge, and a lost control bit would show up as a wrong echo bit in the following frame.

// File: rtl/biss_pkg.sv
package biss_pkg;
  localparam int CRC_W = 6;
  localparam logic [CRC_W-1:0] CRC_POLY = 6'h03; // x^6 + x + 1, top term implicit

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_BUSY,
    ST_SEND,
    ST_TAIL,
    ST_REARM
  } tx_state_e;
endpackage

// File: rtl/biss_ma_front.sv
module biss_ma_front #(
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ma_i,
  output logic ma_lvl_o,
  output logic rise_o,
  output logic tmo_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ma_d_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   ma_s, edge_s;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= ma_i;
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], ma_i};
    end
  endgenerate

  assign ma_s   = sync_q[SYNC_STAGES-1];
  assign edge_s = ma_s ^ ma_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ma_d_q <= 1'b1;
      cnt_q  <= CNT_SAT; // start saturated: no timeout out of reset
    end else begin
      ma_d_q <= ma_s;
      if (edge_s)              cnt_q <= '0;
      else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ma_lvl_o = ma_s;
  assign rise_o   = ma_s & ~ma_d_q;
  assign tmo_o    = ~edge_s & (cnt_q == CNT_LAST);

  p_tmo_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |=> !tmo_o);
  p_tmo_needs_rest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !tmo_o);
endmodule

// File: rtl/biss_crc6.sv
module biss_crc6 #(
  parameter int DATA_W = 18
) (
  input  logic [DATA_W-1:0]          data_i,
  output logic [biss_pkg::CRC_W-1:0] crc_o
);
  import biss_pkg::*;

  always_comb begin
    logic [CRC_W-1:0] r;
    logic             fb;
    r = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ data_i[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    crc_o = r;
  end
endmodule

// File: rtl/biss_tx_seq.sv
module biss_tx_seq #(
  parameter int POS_W    = 16,
  parameter int BUSY_CYC = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rise_i,
  input  logic                       tmo_i,
  input  logic                       ma_lvl_i,
  input  logic [POS_W-1:0]           pos_i,
  input  logic                       err_i,
  input  logic                       warn_i,
  input  logic [biss_pkg::CRC_W-1:0] crc_i,
  output logic                       sl_o,
  output logic                       cdm_o
);
  import biss_pkg::*;

  localparam int FRAME_W = 2 + POS_W + 2 + CRC_W;
  localparam int FCNT_W  = $clog2(FRAME_W + 1);
  localparam int BCNT_W  = $clog2(BUSY_CYC + 2);
  localparam logic [FCNT_W-1:0] FRAME_LAST = FCNT_W'(FRAME_W);
  localparam logic [BCNT_W-1:0] BUSY_LAST  = BCNT_W'(BUSY_CYC);
  localparam int POS_TOP = FRAME_W - 3;

  tx_state_e          state_q;
  logic [FRAME_W-1:0] frame_q;
  logic [FCNT_W-1:0]  bit_cnt_q;
  logic [BCNT_W-1:0]  busy_cnt_q;
  logic               sl_q, cdm_q;
  logic               active;

  assign active = (state_q != ST_IDLE) && (state_q != ST_REARM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      frame_q    <= '0;
      bit_cnt_q  <= '0;
      busy_cnt_q <= '0;
      sl_q       <= 1'b1;
      cdm_q      <= 1'b0;
    end else if (tmo_i && active) begin
      cdm_q   <= ma_lvl_i;
      sl_q    <= 1'b1;
      state_q <= ma_lvl_i ? ST_IDLE : ST_REARM;
    end else begin
      unique case (state_q)
        ST_IDLE: if (rise_i) begin
          frame_q <= {1'b1, cdm_q, pos_i, err_i, warn_i, ~crc_i};
          state_q <= ST_ACK;
        end
        ST_ACK: if (rise_i) begin
          sl_q       <= 1'b0;
          busy_cnt_q <= '0;
          state_q    <= ST_BUSY;
        end
        ST_BUSY: if (rise_i) begin
          if (busy_cnt_q == BUSY_LAST) begin
            sl_q      <= frame_q[FRAME_W-1];
            frame_q   <= {frame_q[FRAME_W-2:0], 1'b0};
            bit_cnt_q <= FCNT_W'(1);
            state_q   <= ST_SEND;
          end else begin
            busy_cnt_q <= busy_cnt_q + 1'b1;
          end
        end
        ST_SEND: if (rise_i) begin
          if (bit_cnt_q == FRAME_LAST) begin
            sl_q    <= 1'b0;
            state_q <= ST_TAIL;
          end else begin
            sl_q      <= frame_q[FRAME_W-1];
            frame_q   <= {frame_q[FRAME_W-2:0], 1'b0};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        ST_TAIL: ;
        ST_REARM: if (ma_lvl_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sl_o  = sl_q;
  assign cdm_o = cdm_q;

  p_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && rise_i) |=>
      (frame_q[POS_TOP -: POS_W] == $past(pos_i)) && sl_o);
  p_ack_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK && rise_i && !tmo_i) |=> !sl_o);
  p_sl_edge_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_i && !tmo_i) |=> $stable(sl_o));
  p_cdm_on_tmo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmo_i |=> $stable(cdm_o));
  p_idle_after_tmo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_i && active) |=> sl_o && (cdm_o == $past(ma_lvl_i)));
  p_tail_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TAIL && !tmo_i) |=> !sl_o);
endmodule

// File: rtl/biss_slave_tx.sv
module biss_slave_tx #(
  parameter int POS_W       = 16,
  parameter int BUSY_CYC    = 4,
  parameter int TIMEOUT_CYC = 125,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ma_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             err_i,
  input  logic             warn_i,
  output logic             sl_o,
  output logic             cdm_o
);
  import biss_pkg::*;

  logic             ma_lvl, rise, tmo;
  logic [CRC_W-1:0] crc;

  biss_ma_front #(
    .SYNC_STAGES(SYNC_STAGES),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_front (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ma_i    (ma_i),
    .ma_lvl_o(ma_lvl),
    .rise_o  (rise),
    .tmo_o   (tmo)
  );

  biss_crc6 #(
    .DATA_W(POS_W + 2)
  ) u_crc (
    .data_i({pos_i, err_i, warn_i}),
    .crc_o (crc)
  );

  biss_tx_seq #(
    .POS_W   (POS_W),
    .BUSY_CYC(BUSY_CYC)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise),
    .tmo_i   (tmo),
    .ma_lvl_i(ma_lvl),
    .pos_i   (pos_i),
    .err_i   (err_i),
    .warn_i  (warn_i),
    .crc_i   (crc),
    .sl_o    (sl_o),
    .cdm_o   (cdm_o)
  );
endmodule

// File: tb/tb_biss_slave_tx.sv
module tb_biss_slave_tx;
  localparam int POS_W   = 16;
  localparam int BUSY    = 3;
  localparam int TMO     = 40;
  localparam int HALF    = 8;
  localparam int FRAME_W = 4 + POS_W + 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ma = 1'b1;
  logic [POS_W-1:0] pos = '0;
  logic             err = 1'b0, warn = 1'b0;
  logic             sl, cdm;

  int n_chk = 0, n_fail = 0;
  logic echo_exp = 1'b0;
  logic rearm_pending = 1'b0;

  always #4 clk = ~clk;

  biss_slave_tx #(
    .POS_W(POS_W), .BUSY_CYC(BUSY), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .ma_i(ma), .pos_i(pos),
    .err_i(err), .warn_i(warn), .sl_o(sl), .cdm_o(cdm)
  );

  function automatic logic [5:0] ref_crc(input logic [POS_W+1:0] d);
    logic [5:0] r = '0;
    for (int i = POS_W + 1; i >= 0; i--) begin
      logic fb = r[5] ^ d[i];
      r = {r[4:0], 1'b0};
      if (fb) r = r ^ 6'h03;
    end
    return r;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(output logic s);
    ma = 1'b1;
    tick(HALF);
    s = sl;
    ma = 1'b0;
    tick(HALF);
  endtask

  // abort_at = 0: full frame; otherwise number of frame bits sent before stopping
  task automatic run_frame(input logic [POS_W-1:0] p, input logic e, input logic w,
                           input logic cdm_bit, input int extra, input int abort_at);
    logic [FRAME_W-1:0] exp_f;
    logic s;
    int n;
    exp_f = {1'b1, echo_exp, p, e, w, ~ref_crc({p, e, w})};
    pos = p; err = e; warn = w;
    ma = 1'b0;
    tick(HALF);
    pulse(s);
    if (rearm_pending) check("R8 rearm rise started no frame", s, 1);
    else               check("R1 capture edge keeps line high", s, 1);
    pos = POS_W'($urandom); err = ~e; warn = ~w; // R1: late changes must not matter
    pulse(s); check("R2 acknowledge low", s, 0);
    for (int i = 0; i < BUSY; i++) begin
      pulse(s); check("R3 busy low", s, 0);
    end
    n = (abort_at == 0) ? FRAME_W : abort_at;
    for (int i = 0; i < n; i++) begin
      pulse(s);
      if (i == 0)                check("R3 start bit", s, 1);
      else if (i == 1)           check("R5 echo bit", s, echo_exp);
      else if (i < FRAME_W - 6)  check("R4 data bit", s, exp_f[FRAME_W-1-i]);
      else                       check("R6 crc bit", s, exp_f[FRAME_W-1-i]);
    end
    if (abort_at == 0)
      for (int i = 0; i < extra; i++) begin
        pulse(s); check("R9 trailing low", s, 0);
      end
    ma = cdm_bit;
    tick(TMO + 10);
    check("R8 line high after timeout", sl, 1);
    check("R7 control bit captured", cdm, cdm_bit);
    echo_exp = cdm_bit;
    rearm_pending = ~cdm_bit;
    if (!cdm_bit) begin
      ma = 1'b1;
      tick(HALF);
      check("R8 idle after rearm rise", sl, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    tick(3);
    check("R10 reset sl", sl, 1);
    check("R10 reset cdm", cdm, 0);
    rst_n = 1'b1;
    tick(4);
    check("R10 sl after release", sl, 1);

    run_frame('0, 1'b0, 1'b0, 1'b1, 0, 0);
    run_frame('1, 1'b1, 1'b1, 1'b0, 2, 0);
    run_frame(16'h8001, 1'b1, 1'b0, 1'b0, 1, 0);
    run_frame(16'h5a3c, 1'b0, 1'b1, 1'b1, 0, 7);   // abort inside position
    run_frame(16'h1234, 1'b0, 1'b0, 1'b0, 3, 0);
    for (int k = 0; k < 30; k++) begin
      int ab;
      ab = ($urandom % 6 == 0) ? 1 + int'($urandom % (FRAME_W - 1)) : 0;
      run_frame(POS_W'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                int'($urandom % 4), ab);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule